// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset request of the chip into one active-low system reset. The requests are power-on, a software-forced reset, a wake-up from a low-power mode, a watchdog expiry and a low level applied to the shared reset pin from outside. Internal requests pull the pin low through an open-drain style enable. A comparator senses the pin level, and that level is synchronized and used as the main-domain reset. External pull-downs on the same net therefore merge with the internal ones.

Two 8-bit control/status registers hold the state that software sees. `ctl0` holds the forced-reset request and the watchdog and clock-monitor enables. `ctl1` holds sticky reset-cause flags and power-saving-mode flags, and each of them is cleared by writing 1. Entering a power-saving mode only records which mode was entered. The wake-up from that mode is what triggers a full reset. The always-on domain reset follows power-on only, so the real-time domain survives every pin-driven reset.

Top module: `sysrst_ctrl`

## Requirements
- R1: While `por_n` is low and for 16 cycles after it rises, `pin_drive_low_o` is 1. During that time `ctl1` reads 0x01 (bit 0 is the power-on cause), `wdog_en_o` is 0 and `clkmon_en_o` is 1. `aon_rst_n_o` rises 2 clock edges after `por_n` rises.
- R2: A write to `ctl0` (`wr_sel_i`=0) with bit 0 set drives `pin_drive_low_o` to 1 in the same cycle. After that write, `ctl0` bit 0 reads 1 and `ctl1` bit 1 (forced cause) is set. `ctl0` bit 0 clears by itself on the edge that ends the reset stretch.
- R3: `pin_drive_low_o` stays 1 for exactly STRETCH (16) cycles after the last cycle in which an internal source was active. A new source inside the stretch restarts the count.
- R4: A pulse on `sleep_enter_i` with mode index m below NUM_MODES sets `ctl1` bit 5+m and causes no reset: `pin_drive_low_o` and `main_rst_n_o` stay as they were.
- R5: A pulse on `wake_i` drives `pin_drive_low_o` to 1 in the same cycle, sets `ctl1` bit 2 and clears the watchdog enable.
- R6: `wdog_expire_i` starts a reset only while `wdog_en_o` is 1. In that case it sets `ctl1` bit 3 and leaves `wdog_en_o` unchanged. Software writes the enable through `ctl0` bit 1.
- R7: An external low on the pin, seen while the block has not driven the pin in the two previous cycles, sets `ctl1` bit 4 and pulls `main_rst_n_o` low without asserting `pin_drive_low_o`. `aon_rst_n_o` stays 1.
- R8: `main_rst_n_o` is 0 whenever `pin_drive_low_o` is 1 or the synchronized pin level is low.
- R9: Any reset (pin driven or sensed low) sets `clkmon_en_o` to 1. Software may clear it through `ctl0` bit 2.
- R10: Writing `ctl1` (`wr_sel_i`=1) clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R11: The sensed pin passes through a two-flop synchronizer. A change of `pin_sense_i` reaches `main_rst_n_o` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pin_sense_i | input | 1 | Comparator output: sensed level of the reset pin |
| pin_drive_low_o | output | 1 | Open-drain enable: 1 pulls the reset pin low |
| main_rst_n_o | output | 1 | Active-low reset for the main domain |
| aon_rst_n_o | output | 1 | Active-low reset for the always-on domain |
| wake_i | input | 1 | Wake-up event from a power-saving mode |
| wdog_expire_i | input | 1 | Watchdog expiry pulse |
| sleep_enter_i | input | 1 | Pulse: a power-saving mode is being entered |
| sleep_mode_i | input | MODE_W (2) | Index of the mode being entered |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects ctl0, 1 selects ctl1 |
| wr_data_i | input | 8 | Write data |
| ctl0_o | output | 8 | ctl0 readback: bit0 force, bit1 watchdog enable, bit2 clock-monitor enable |
| ctl1_o | output | 8 | ctl1 readback: bits 4:0 cause flags, bits 5+ mode flags |
| wdog_en_o | output | 1 | Watchdog enable |
| clkmon_en_o | output | 1 | Clock-monitor enable |

## Verification
The bound checker checks several rules on every cycle. A forced write or a wake pulse must pull the pin low in the same cycle. The stretch after the last internal source must last exactly 16 cycles. A driven pin must always hold the main domain in reset. A watchdog expiry must keep the enable. A driven pin must re-enable the clock monitor. A rising main reset must reflect the pin level two edges earlier. The directed scenarios cover what needs a history or a readback. That means the cause and mode flags after each source, write-1-to-clear, the POR sequence and the always-on release. It also includes the gating of an expiry while the watchdog is disabled, the self-clearing force request and the masking of the block's own pull-down when it tells an external reset apart.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int unsigned CAUSE_N = 5;
  localparam int unsigned REG_W   = 8;

  // Bit positions of the cause flags in ctl1
  typedef enum logic [2:0] {
    CS_POR   = 3'd0,
    CS_FORCE = 3'd1,
    CS_WAKE  = 3'd2,
    CS_WDOG  = 3'd3,
    CS_EXT   = 3'd4
  } cause_e;

  // Bit positions in ctl0
  localparam int unsigned C0_FORCE  = 0;
  localparam int unsigned C0_WDOG   = 1;
  localparam int unsigned C0_CLKMON = 2;
endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch #(
  parameter int unsigned STRETCH = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig_i,
  output logic hold_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    if (trig_i) cnt_d = LOAD;
    else        cnt_d = cnt_q - ONE;
  end

  // Counter starts loaded so power-on gets a full stretch
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hold_o = (cnt_q != '0);
  assign done_o = !trig_i && (cnt_q == ONE);
endmodule

// File: rtl/sysrst_regs.sv
module sysrst_regs
  import sysrst_pkg::*;
#(
  parameter int unsigned NUM_MODES = 3,
  parameter int unsigned MODE_W    = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [CAUSE_N-1:0] cause_set_i,
  input  logic               sleep_enter_i,
  input  logic [MODE_W-1:0]  sleep_mode_i,
  input  logic               rst_active_i,
  input  logic               wake_i,
  input  logic               force_done_i,
  output logic               force_o,
  output logic               wdog_en_o,
  output logic               clkmon_en_o,
  output logic [REG_W-1:0]   ctl0_o,
  output logic [REG_W-1:0]   ctl1_o
);
  logic                 wr0, wr1;
  logic                 force_q, force_d;
  logic                 wdog_q, wdog_d;
  logic                 clkmon_q, clkmon_d;
  logic [CAUSE_N-1:0]   cause_q, cause_d;
  logic [NUM_MODES-1:0] mode_q, mode_d, mode_set, mode_clr;
  logic [CAUSE_N-1:0]   cause_clr;

  always_comb begin
    wr0 = wr_en_i && !wr_sel_i;
    wr1 = wr_en_i &&  wr_sel_i;

    // Forced request: set by write, cleared when the stretch ends
    force_d = force_q;
    if (wr0 && wr_data_i[C0_FORCE]) force_d = 1'b1;
    else if (force_done_i)          force_d = 1'b0;

    // Watchdog enable: wake-up clears it, otherwise software owns it
    wdog_d = wdog_q;
    if (wake_i)   wdog_d = 1'b0;
    else if (wr0) wdog_d = wr_data_i[C0_WDOG];

    // Clock monitor: any reset re-arms it
    clkmon_d = clkmon_q;
    if (rst_active_i) clkmon_d = 1'b1;
    else if (wr0)     clkmon_d = wr_data_i[C0_CLKMON];

    mode_set = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (sleep_enter_i && (32'(sleep_mode_i) == 32'(m))) mode_set[m] = 1'b1;
    end

    cause_clr = wr1 ? wr_data_i[CAUSE_N-1:0] : '0;
    mode_clr  = wr1 ? wr_data_i[CAUSE_N +: NUM_MODES] : '0;
    cause_d   = (cause_q & ~cause_clr) | cause_set_i;
    mode_d    = (mode_q & ~mode_clr) | mode_set;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      force_q  <= 1'b0;
      wdog_q   <= 1'b0;
      clkmon_q <= 1'b1;
      cause_q  <= CAUSE_N'(1) << CS_POR;
      mode_q   <= '0;
    end else begin
      force_q  <= force_d;
      wdog_q   <= wdog_d;
      clkmon_q <= clkmon_d;
      cause_q  <= cause_d;
      mode_q   <= mode_d;
    end
  end

  always_comb begin
    ctl0_o = '0;
    ctl0_o[C0_FORCE]  = force_q;
    ctl0_o[C0_WDOG]   = wdog_q;
    ctl0_o[C0_CLKMON] = clkmon_q;
    ctl1_o = '0;
    ctl1_o[CAUSE_N-1:0]        = cause_q;
    ctl1_o[CAUSE_N +: NUM_MODES] = mode_q;
  end

  assign force_o     = force_q;
  assign wdog_en_o   = wdog_q;
  assign clkmon_en_o = clkmon_q;
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int unsigned STRETCH   = 16,
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned NUM_MODES = 3,
  parameter int unsigned MODE_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_sense_i,
  output logic              pin_drive_low_o,
  output logic              main_rst_n_o,
  output logic              aon_rst_n_o,
  input  logic              wake_i,
  input  logic              wdog_expire_i,
  input  logic              sleep_enter_i,
  input  logic [MODE_W-1:0] sleep_mode_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  ctl0_o,
  output logic [REG_W-1:0]  ctl1_o,
  output logic              wdog_en_o,
  output logic              clkmon_en_o
);
  logic               pin_sync;
  logic               force_now, wdog_evt, trig, hold, stretch_done;
  logic               ext_low, rst_active;
  logic [SYNC_N-1:0]  drv_hist_q, drv_hist_d;
  logic [CAUSE_N-1:0] cause_set;
  logic               force_q;

  sysrst_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst_n(por_n), .d_i(pin_sense_i), .q_o(pin_sync)
  );

  sysrst_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_aon_sync (
    .clk(clk), .arst_n(por_n), .d_i(1'b1), .q_o(aon_rst_n_o)
  );

  always_comb begin
    force_now = wr_en_i && !wr_sel_i && wr_data_i[C0_FORCE];
    wdog_evt  = wdog_expire_i && wdog_en_o;
    trig      = force_now || wake_i || wdog_evt;
  end

  sysrst_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .arst_n(por_n), .trig_i(trig), .hold_o(hold), .done_o(stretch_done)
  );

  assign pin_drive_low_o = trig || hold;

  // Own pull-down history: a low pin is external only after the
  // synchronizer has flushed every cycle the block drove it
  always_comb drv_hist_d = {drv_hist_q[SYNC_N-2:0], pin_drive_low_o};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) drv_hist_q <= '1;
    else        drv_hist_q <= drv_hist_d;
  end

  always_comb begin
    ext_low    = !pin_sync && !pin_drive_low_o && (drv_hist_q == '0);
    rst_active = pin_drive_low_o || !pin_sync;
    cause_set  = '0;
    cause_set[CS_FORCE] = force_now;
    cause_set[CS_WAKE]  = wake_i;
    cause_set[CS_WDOG]  = wdog_evt;
    cause_set[CS_EXT]   = ext_low;
  end

  assign main_rst_n_o = pin_sync && !pin_drive_low_o;

  sysrst_regs #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .arst_n(por_n),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .cause_set_i(cause_set),
    .sleep_enter_i(sleep_enter_i), .sleep_mode_i(sleep_mode_i),
    .rst_active_i(rst_active), .wake_i(wake_i),
    .force_done_i(stretch_done),
    .force_o(force_q), .wdog_en_o(wdog_en_o), .clkmon_en_o(clkmon_en_o),
    .ctl0_o(ctl0_o), .ctl1_o(ctl1_o)
  );
endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk #(
  parameter int unsigned STRETCH = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       pin_sense_i,
  input logic       pin_drive_low_o,
  input logic       main_rst_n_o,
  input logic       wake_i,
  input logic       wdog_expire_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       wdog_en_o,
  input logic       clkmon_en_o
);
  localparam int unsigned CW = $clog2(STRETCH + 2);

  logic          src;
  logic [CW-1:0] run_q;

  assign src = (wr_en_i && !wr_sel_i && wr_data_i[0]) || wake_i
               || (wdog_expire_i && wdog_en_o);

  // Cycles of drive since the last source, saturating
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_q <= '0;
    else if (src) run_q <= '0;
    else if (pin_drive_low_o && run_q != CW'(STRETCH + 1)) run_q <= run_q + CW'(1);
  end

  assert_force_now_R2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en_i && !wr_sel_i && wr_data_i[0]) |-> pin_drive_low_o);

  assert_stretch_len_R3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_drive_low_o) |-> (run_q == CW'(STRETCH)));

  assert_wake_drive_R5: assert property (@(posedge clk) disable iff (!por_n)
    wake_i |-> pin_drive_low_o);

  assert_wake_wdog_off_R5: assert property (@(posedge clk) disable iff (!por_n)
    wake_i |=> !wdog_en_o);

  assert_wdog_keep_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wdog_expire_i && wdog_en_o && !wake_i && !(wr_en_i && !wr_sel_i)) |=> wdog_en_o);

  assert_main_follow_R8: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low_o |-> !main_rst_n_o);

  assert_clkmon_rearm_R9: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low_o |=> clkmon_en_o);

  assert_sync_delay_R11: assert property (@(posedge clk) disable iff (!por_n)
    $rose(main_rst_n_o) |-> $past(pin_sense_i, 2));
endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(.STRETCH(STRETCH)) u_chk (
  .clk(clk), .por_n(por_n), .pin_sense_i(pin_sense_i),
  .pin_drive_low_o(pin_drive_low_o), .main_rst_n_o(main_rst_n_o),
  .wake_i(wake_i), .wdog_expire_i(wdog_expire_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .wdog_en_o(wdog_en_o), .clkmon_en_o(clkmon_en_o)
);

// File: tb/sim_sysrst_ctrl.sv
module sim_sysrst_ctrl;
  logic       clk = 1'b0;
  logic       por_n;
  logic       ext_low;
  logic       pin_sense, drive_low, main_rst_n, aon_rst_n;
  logic       wake, wdog_exp, sleep_en;
  logic [1:0] sleep_mode;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data, ctl0, ctl1;
  logic       wdog_en, clkmon_en;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  // Wired pin: low when the block or an external source pulls it
  assign pin_sense = !(drive_low || ext_low);

  sysrst_ctrl u0 (
    .clk(clk), .por_n(por_n), .pin_sense_i(pin_sense),
    .pin_drive_low_o(drive_low), .main_rst_n_o(main_rst_n), .aon_rst_n_o(aon_rst_n),
    .wake_i(wake), .wdog_expire_i(wdog_exp),
    .sleep_enter_i(sleep_en), .sleep_mode_i(sleep_mode),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctl0_o(ctl0), .ctl1_o(ctl1), .wdog_en_o(wdog_en), .clkmon_en_o(clkmon_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance one cycle; inputs are changed and checked near the falling edge
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    #1;
  endtask

  task automatic idle_inputs();
    wake = 0; wdog_exp = 0; sleep_en = 0; sleep_mode = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    idle_inputs();
  endtask

  task automatic t_por();
    por_n = 0; ext_low = 0; idle_inputs();
    tick(3);
    chk("R1 drive in por", 32'(drive_low), 1);
    chk("R1 ctl1 in por", 32'(ctl1), 32'h01);
    chk("R1 ctl0 in por", 32'(ctl0), 32'h04);
    chk("R1 aon in por", 32'(aon_rst_n), 0);
    por_n = 1; #1;
    tick(2);
    chk("R1 aon release", 32'(aon_rst_n), 1);
    tick(13);
    chk("R1 stretch k15", 32'(drive_low), 1);
    tick();
    chk("R1 stretch end", 32'(drive_low), 0);
    tick();
    chk("R11 main still low", 32'(main_rst_n), 0);
    tick();
    chk("R11 main released", 32'(main_rst_n), 1);
    chk("R6 wdog off after por", 32'(wdog_en), 0);
  endtask

  task automatic t_w1c();
    write_reg(1'b1, 8'h01);
    chk("R10 por flag cleared", 32'(ctl1), 32'h00);
  endtask

  task automatic t_sleep();
    sleep_en = 1; sleep_mode = 2; #1;
    chk("R4 no drive on sleep", 32'(drive_low), 0);
    tick();
    idle_inputs();
    chk("R4 mode flag", 32'(ctl1), 32'h80);
    tick(3);
    chk("R4 main stays up", 32'(main_rst_n), 1);
    chk("R4 no drive later", 32'(drive_low), 0);
  endtask

  task automatic t_force();
    wr_en = 1; wr_sel = 0; wr_data = 8'h05; #1;
    chk("R2 same cycle drive", 32'(drive_low), 1);
    chk("R8 main low on drive", 32'(main_rst_n), 0);
    tick();
    idle_inputs();
    chk("R2 force flag set", 32'(ctl0[0]), 1);
    chk("R2 force cause", 32'(ctl1[1]), 1);
    tick(15);
    chk("R3 held 16th cycle", 32'(drive_low), 1);
    tick();
    chk("R3 released", 32'(drive_low), 0);
    chk("R2 force self-clear", 32'(ctl0[0]), 0);
    tick(5);
    chk("R7 no ext on own drive", 32'(ctl1), 32'h82);
  endtask

  task automatic t_wdog();
    wdog_exp = 1; #1;
    chk("R6 gated drive", 32'(drive_low), 0);
    tick();
    idle_inputs();
    chk("R6 gated flag", 32'(ctl1[3]), 0);
    write_reg(1'b0, 8'h06);
    chk("R6 enable written", 32'(wdog_en), 1);
    wdog_exp = 1; #1;
    chk("R6 expiry drives", 32'(drive_low), 1);
    tick();
    idle_inputs();
    chk("R6 wdog flag", 32'(ctl1[3]), 1);
    tick(4);
    wdog_exp = 1;
    tick();
    idle_inputs();
    tick(15);
    chk("R3 retrigger held", 32'(drive_low), 1);
    tick();
    chk("R3 retrigger end", 32'(drive_low), 0);
    chk("R6 enable kept", 32'(wdog_en), 1);
    tick(4);
  endtask

  task automatic t_wake();
    write_reg(1'b0, 8'h02);
    chk("R9 sw clears clkmon", 32'(clkmon_en), 0);
    wake = 1; #1;
    chk("R5 wake drives", 32'(drive_low), 1);
    tick();
    idle_inputs();
    chk("R5 wake flag", 32'(ctl1[2]), 1);
    chk("R5 wdog cleared", 32'(wdog_en), 0);
    chk("R9 clkmon rearmed", 32'(clkmon_en), 1);
    tick(20);
    chk("R7 no ext after wake", 32'(ctl1[4]), 0);
  endtask

  task automatic t_ext();
    write_reg(1'b1, 8'hFF);
    chk("R10 clear all", 32'(ctl1), 32'h00);
    write_reg(1'b0, 8'h00);
    ext_low = 1;
    tick();
    chk("R11 ext latency", 32'(main_rst_n), 1);
    tick();
    chk("R7 main low on ext", 32'(main_rst_n), 0);
    chk("R7 no drive on ext", 32'(drive_low), 0);
    chk("R7 aon kept", 32'(aon_rst_n), 1);
    tick(3);
    ext_low = 0;
    tick();
    chk("R11 release latency", 32'(main_rst_n), 0);
    tick();
    chk("R7 main back", 32'(main_rst_n), 1);
    chk("R7 ext flag", 32'(ctl1), 32'h10);
    chk("R9 clkmon on ext", 32'(clkmon_en), 1);
  endtask

  initial begin
    t_por();
    t_w1c();
    t_sleep();
    t_force();
    t_wdog();
    t_wake();
    t_ext();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule